// File: doc/BRIEF.md
# Accumulator Shift and Rotate Unit

This unit executes the shift-class instruction of a small 16-bit accumulator machine. The execute stage presents an instruction word, a qualifying strobe and the current accumulator. When the top four bits of the word hold the shift-class opcode, the unit moves the accumulator bits left or right by the count in the low field of the word. Depending on a two-bit selector, the vacated positions are filled with zeros or the bits leaving one end re-enter at the other.

The new accumulator value is registered and leaves the unit one clock after issue, together with a write strobe that the register file uses for the write-back. Any other opcode, or an issue strobe held low, produces no write strobe and leaves the output word unchanged. No flags are produced, and there is no arithmetic shift.

Top module: `accShiftUnit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `resultValid` is 0 and `accOut` is 0x0000.
- R2: When `issueValid` is 1 and `instrWord[15:12]` equals 2, `resultValid` is 1 on the following clock and `accOut` carries the new value.
- R3: When `issueValid` is 0 or `instrWord[15:12]` is not 2, `resultValid` is 0 on the following clock and `accOut` keeps its previous value.
- R4: Selector `instrWord[11:10]` = 00 shifts left and fills the vacated low bits with zeros.
- R5: Selector 01 shifts right and fills the vacated high bits with zeros (no sign extension).
- R6: Selector 10 rotates left: bits leaving bit 15 re-enter at bit 0.
- R7: Selector 11 rotates right: bits leaving bit 0 re-enter at bit 15.
- R8: The count is `instrWord[3:0]` (0 to 15). A count of 0 returns the accumulator unchanged for all four selectors.
- R9: `instrWord[9:4]` has no effect on the result.
- R10: With accumulator 0x0F0F and count 3 the results are 0x7878 (00), 0x01E1 (01), 0x7878 (10) and 0xE1E1 (11). Word 0x2403 is a right shift by 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Instruction word and accumulator are valid this cycle |
| instrWord | input | 16 | Instruction word: opcode 15:12, selector 11:10, count 3:0 |
| accIn | input | 16 | Current accumulator value |
| resultValid | output | 1 | Write-back strobe for `accOut` |
| accOut | output | 16 | New accumulator value |

## Verification
Capture of a new result and hold of the previous one can fall on neighbouring cycles. In that case the output register either loads or keeps its value, depending only on the word issued one clock earlier. The bench provokes this by interleaving shift-class words back to back with other opcodes and with idle cycles. It judges each cycle by the expected write strobe and by comparing `accOut` with the last value the scoreboard accepted. Rotates and zero-fill shifts of the same data are also issued on consecutive cycles, so that a wrong wrap or fill choice shows up at once as a mismatched word.

// File: rtl/accShiftPkg.sv
package accShiftPkg;
  localparam int DATA_W    = 16;
  localparam int INSTR_W   = 16;
  localparam int OPC_W     = 4;
  localparam int SEL_LSB   = 10;
  localparam int CNT_W     = $clog2(DATA_W);
  localparam logic [OPC_W-1:0] SHIFT_OPC = 4'h2;

  typedef enum logic [1:0] {
    OP_SHL = 2'b00,
    OP_SHR = 2'b01,
    OP_ROL = 2'b10,
    OP_ROR = 2'b11
  } shiftOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             dirRight;
    logic             wrap;
    logic [CNT_W-1:0] amount;
  } shiftStrobe_t;
endpackage

// File: rtl/accShiftCtl.sv
module accShiftCtl
  import accShiftPkg::*;
#(
  parameter int IW = INSTR_W
) (
  input  logic          issueValid,
  input  logic [IW-1:0] instrWord,
  output shiftStrobe_t  strobe
);
  localparam int RSV_HI = SEL_LSB - 1;
  localparam int RSV_LO = CNT_W;

  logic [OPC_W-1:0] opcField;
  shiftOp_e         selField;
  logic             unusedReserved;

  assign opcField = instrWord[IW-1 -: OPC_W];
  assign selField = shiftOp_e'(instrWord[SEL_LSB +: 2]);
  // reserved field between selector and count carries no meaning
  assign unusedReserved = ^instrWord[RSV_HI:RSV_LO];

  always_comb begin
    strobe          = '0;
    strobe.load     = issueValid && (opcField == SHIFT_OPC);
    strobe.amount   = instrWord[CNT_W-1:0];
    unique case (selField)
      OP_SHL: begin strobe.dirRight = 1'b0; strobe.wrap = 1'b0; end
      OP_SHR: begin strobe.dirRight = 1'b1; strobe.wrap = 1'b0; end
      OP_ROL: begin strobe.dirRight = 1'b0; strobe.wrap = 1'b1; end
      OP_ROR: begin strobe.dirRight = 1'b1; strobe.wrap = 1'b1; end
      default: begin strobe.dirRight = 1'b0; strobe.wrap = 1'b0; end
    endcase
  end
endmodule

// File: rtl/accShiftDp.sv
module accShiftDp
  import accShiftPkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  shiftStrobe_t  strobe,
  input  logic [DW-1:0] accIn,
  output logic          resultValid,
  output logic [DW-1:0] accOut
);
  localparam int STAGES = CNT_W;

  logic [DW-1:0] stageVal [0:STAGES];

  assign stageVal[0] = accIn;

  // logarithmic barrel: stage k moves by 2**k when amount bit k is set
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [DW-1:0] cur;
    logic [S-1:0]  fillLeft;
    logic [S-1:0]  fillRight;
    logic [DW-1:0] movedLeft;
    logic [DW-1:0] movedRight;

    assign cur        = stageVal[k];
    assign fillLeft   = strobe.wrap ? cur[DW-1 -: S] : '0;
    assign fillRight  = strobe.wrap ? cur[S-1:0]     : '0;
    assign movedLeft  = {cur[DW-1-S:0], fillLeft};
    assign movedRight = {fillRight, cur[DW-1:S]};

    always_comb begin
      if (!strobe.amount[k])   stageVal[k+1] = cur;
      else if (strobe.dirRight) stageVal[k+1] = movedRight;
      else                      stageVal[k+1] = movedLeft;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      accOut      <= '0;
    end else begin
      resultValid <= strobe.load;
      if (strobe.load) accOut <= stageVal[STAGES];
    end
  end
endmodule

// File: rtl/accShiftUnit.sv
module accShiftUnit
  import accShiftPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = INSTR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          issueValid,
  input  logic [IW-1:0] instrWord,
  input  logic [DW-1:0] accIn,
  output logic          resultValid,
  output logic [DW-1:0] accOut
);
  shiftStrobe_t strobe;

  accShiftCtl #(.IW(IW)) ctl_i (
    .issueValid (issueValid),
    .instrWord  (instrWord),
    .strobe     (strobe)
  );

  accShiftDp #(.DW(DW)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .accIn       (accIn),
    .resultValid (resultValid),
    .accOut      (accOut)
  );
endmodule

// File: rtl/accShiftChecker.sv
module accShiftChecker (
  input logic        clk,
  input logic        rstN,
  input logic        issueValid,
  input logic [15:0] instrWord,
  input logic [15:0] accIn,
  input logic        resultValid,
  input logic [15:0] accOut
);
  logic isShift;
  assign isShift = issueValid && (instrWord[15:12] == 4'h2);

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (!resultValid && accOut == 16'h0000));

  p_issue_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    isShift |=> resultValid);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !isShift |=> (!resultValid && $stable(accOut)));

  p_left_zero_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isShift && instrWord[11:10] == 2'b00 && instrWord[3:0] != 4'd0)
      |=> !accOut[0]);

  p_right_zero_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isShift && instrWord[11:10] == 2'b01 && instrWord[3:0] != 4'd0)
      |=> !accOut[15]);

  // covers R6 and R7: a rotate keeps every set bit
  p_rotate_keeps_ones_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isShift && instrWord[11])
      |=> ($countones(accOut) == $countones($past(accIn))));

  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isShift && instrWord[3:0] == 4'd0) |=> (accOut == $past(accIn)));
endmodule

bind accShiftUnit accShiftChecker chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .issueValid  (issueValid),
  .instrWord   (instrWord),
  .accIn       (accIn),
  .resultValid (resultValid),
  .accOut      (accOut)
);

// File: tb/accShiftUnit_tb_top.sv
`timescale 1ns/1ps
module accShiftUnit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [15:0] instrWord = 16'h0000;
  logic [15:0] accIn = 16'h0000;
  logic        resultValid;
  logic [15:0] accOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] value;
    string       req;
  } expItem_t;

  expItem_t    expQ[$];
  logic [15:0] lastAccepted = 16'h0000;

  always #5 clk = ~clk;

  accShiftUnit dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instrWord(instrWord),
    .accIn(accIn), .resultValid(resultValid), .accOut(accOut)
  );

  function automatic logic [15:0] model(input logic [1:0] sel,
                                        input int n, input logic [15:0] a);
    logic [31:0] wide;
    logic [31:0] dbl;
    wide = {16'h0000, a};
    dbl  = {a, a};
    case (sel)
      2'b00:   return 16'((wide << n) & 32'hFFFF);
      2'b01:   return 16'(wide >> n);
      2'b10:   return 16'(dbl >> (16 - n));
      default: return 16'(dbl >> n);
    endcase
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: present a word at the falling edge, push expectation
  task automatic issue(input logic [15:0] w, input logic [15:0] a,
                       input string req);
    @(negedge clk);
    issueValid = 1'b1;
    instrWord  = w;
    accIn      = a;
    if (w[15:12] == 4'h2) begin
      expItem_t it;
      it.value = model(w[11:10], int'(w[3:0]), a);
      it.req   = req;
      expQ.push_back(it);
    end
  endtask

  task automatic idle(input logic [15:0] w, input logic v);
    @(negedge clk);
    issueValid = v;
    instrWord  = w;
    accIn      = 16'hA5C3;
  endtask

  // monitor: judge each cycle at the falling edge
  initial begin
    @(posedge rstN);
    forever begin
      @(negedge clk);
      if (resultValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected strobe", accOut, lastAccepted);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(accOut == it.value, it.req, accOut, it.value);
          lastAccepted = it.value;
        end
      end else begin
        check(accOut == lastAccepted, "R3 hold", accOut, lastAccepted);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 16'h0, 16'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!resultValid && accOut == 16'h0, "R1 in reset", accOut, 16'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!resultValid && accOut == 16'h0, "R1 after reset", accOut, 16'h0);

    // R10 examples, back to back
    issue(16'h2003, 16'h0F0F, "R10 R4 shl");
    issue(16'h2403, 16'h0F0F, "R10 R5 shr");
    issue(16'h2803, 16'h0F0F, "R10 R6 rol");
    issue(16'h2C03, 16'h0F0F, "R10 R7 ror");
    // R8 zero count, all selectors
    for (int s = 0; s < 4; s++)
      issue({4'h2, 2'(s), 10'h000}, 16'h9C35, "R8 zero count");
    // R9 reserved bits set
    issue(16'h27F3, 16'h0F0F, "R9 reserved ignored");
    issue(16'h2BF5, 16'h8001, "R9 R6 reserved ignored");
    // R3: other opcodes and idle between shifts
    idle(16'h3003, 1'b1);
    idle(16'h2403, 1'b0);
    issue(16'h2C01, 16'h0001, "R2 R7 wrap to msb");
    idle(16'h1C01, 1'b1);
    idle(16'hF000, 1'b1);
    // boundary counts
    issue(16'h200F, 16'hFFFF, "R4 count 15");
    issue(16'h240F, 16'hFFFF, "R5 count 15");
    issue(16'h280F, 16'h8000, "R6 count 15");
    issue(16'h2C0F, 16'h0001, "R7 count 15");
    issue(16'h2401, 16'h8000, "R5 no sign fill");
    // pattern sweep
    for (int i = 0; i < 48; i++) begin
      logic [15:0] a;
      logic [15:0] w;
      a = 16'(i * 16'h3B5D + 16'h1234);
      w = {4'h2, 2'(i % 4), 6'(i * 7), 4'(i % 16)};
      issue(w, a, (i % 4 == 0) ? "R4 sweep" : (i % 4 == 1) ? "R5 sweep" :
                  (i % 4 == 2) ? "R6 sweep" : "R7 sweep");
      if (i % 5 == 0) idle(16'h5000, 1'b1);
    end
    idle(16'h0000, 1'b0);
    idle(16'h0000, 1'b0);
    @(negedge clk);
    check(expQ.size() == 0, "R2 all results seen", 16'(expQ.size()), 16'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule